// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block watches a key matrix built from six drive lines and five sense lines, which gives up to thirty keys. While no key is down it does not scan. Each drive line rests at a level set by the power mode. When a press pulls a sense line high, the block runs scan rounds. Each round drives one line at a time and captures the matrix twice. The captured word is accepted only when both passes match. The block then holds the word in its key register and pulls an active-low read request to the host low.

The key word is handed over under host control. The host watches the request line and reads the key register. It then pulses a read-done strobe. Until that strobe arrives the key register is frozen and no new round runs. A slow host therefore stalls the scanner, and no event is lost or overwritten. Two mode bits can give the first one or two drive lines to a segment driver. Two sleep bits choose which drive lines stay high at rest, and therefore which keys can wake the block. The read request is masked while the serial link's chip-select is active.

Time is counted in ticks T, with one tick every `TICK_DIV` clocks. Each drive line holds for 64T, so a pass over six lines takes 384T. A round is two passes plus a 32T compare gap, which makes 800T.

Top module: `kscan_top`

## Requirements
- R1: The key at drive line k (0..5) and sense line j (0..4) appears at key_bits bit 5k+j.
- R2: While idle, no round runs and drive_out shows the rest pattern. In normal power mode (sleep_sel = 00) with line_mode = 00, that pattern is all ones. A round starts only when a synchronized sense line goes high.
- R3: If both passes of a round match and are non-zero, the key register takes that word and req_n goes low 800T after the round started. This is 803 clocks after the press when TICK_DIV = 1, counting the two synchronizer stages and the wake cycle. The key register then stays stable until read-done.
- R4: If the passes differ, the round repeats, so a press that changes in the first round is reported 1600T after the scan started. A press shorter than one round is never reported.
- R5: Several held keys set several bits. A round whose passes are both zero returns the block to idle without a request.
- R6: A one-cycle rd_done pulse while a request is pending raises req_n on the next cycle and starts a new round at once. If the keys are still held, a new request follows 800T later.
- R7: While cs_busy is 1, req_n is 1. When cs_busy falls, a pending request shows again.
- R8: line_mode 00 drives all six lines. 01 releases line 0, and 1x releases lines 0 and 1. Released lines stay low, and their key bits read 0.
- R9: sleep_sel sets the rest pattern (bit 5 is line 5): 00 gives all lines, 01 gives 6'b100000, 10 gives 6'b110000, 11 gives 6'b111110. In sleep, only lines that rest high are scanned or can wake the block.
- R10: sleep_ack is 1 when the round that raised the request began with sleep_sel non-zero, and 0 otherwise.
- R11: While rst_n is low, key_bits is 0, req_n is 1, sleep_ack is 0 and no round runs.
- R12: During a pass, at most one drive line is high, and line s is driven during ticks 64s..64s+63 of the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 5 | Sense lines from the matrix, pulled low externally |
| sleep_sel | input | 2 | Power mode; non-zero is sleep and picks the rest pattern |
| line_mode | input | 2 | Gives drive lines 0/1 to the segment driver |
| cs_busy | input | 1 | Serial chip-select active; masks the request |
| rd_done | input | 1 | One-cycle pulse after the host has read the key word |
| drive_out | output | 6 | Drive lines to the matrix |
| key_bits | output | 30 | Confirmed key word, row-major |
| sleep_ack | output | 1 | Request came from a round started in sleep |
| req_n | output | 1 | Active-low read request |

## Verification
The bench changes which key is held in the middle of the second pass. A design that trusts one pass would report the first key at 800T instead of the second key at 1600T. A release before the round ends must give no request at all, which catches a design that reports a mismatched pair. Released and sleep-low lines must produce neither a wake nor key bits, so a design that ignores the masks shows stray bits or wakes on a dead line. Requests repeated after read-done, chip-select masking and reset while a request is pending each check that the request and the key register are cleared or held at the right cycle.

// File: rtl/kscan_pkg.sv
`timescale 1ns/1ps
package kscan_pkg;
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_SCAN = 2'd1,
    KS_WAIT = 2'd2
  } ks_state_e;
endpackage

// File: rtl/kscan_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for the sense lines.
module kscan_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/kscan_tick.sv
`timescale 1ns/1ps
// Divides the clock down to the scan time unit T.
module kscan_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;
  assign tick = (cnt == CW'(DIV - 1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/kscan_capture.sv
`timescale 1ns/1ps
// Holds the two passes of a round; each slot end writes one row.
module kscan_capture #(
  parameter int N_DRV = 6,
  parameter int N_SNS = 5,
  localparam int NK   = N_DRV * N_SNS,
  localparam int SW   = $clog2(N_DRV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  logic             pass_sel,
  input  logic [SW-1:0]    slot,
  input  logic [N_SNS-1:0] sense,
  input  logic [N_DRV-1:0] act,
  output logic [NK-1:0]    pass_a,
  output logic [NK-1:0]    pass_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_a <= '0;
      pass_b <= '0;
    end else if (smp) begin
      for (int k = 0; k < N_DRV; k++) begin
        if (slot == SW'(k)) begin
          if (pass_sel) pass_b[k*N_SNS +: N_SNS] <= sense & {N_SNS{act[k]}};
          else          pass_a[k*N_SNS +: N_SNS] <= sense & {N_SNS{act[k]}};
        end
      end
    end
  end
endmodule

// File: rtl/kscan_top.sv
`timescale 1ns/1ps
module kscan_top
  import kscan_pkg::*;
#(
  parameter int N_DRV    = 6,
  parameter int N_SNS    = 5,
  parameter int SLOT_T   = 64,
  parameter int GAP_T    = 32,
  parameter int TICK_DIV = 1,
  localparam int NK      = N_DRV * N_SNS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SNS-1:0] key_in,
  input  logic [1:0]       sleep_sel,
  input  logic [1:0]       line_mode,
  input  logic             cs_busy,
  input  logic             rd_done,
  output logic [N_DRV-1:0] drive_out,
  output logic [NK-1:0]    key_bits,
  output logic             sleep_ack,
  output logic             req_n
);
  localparam int SCAN_T  = N_DRV * SLOT_T;
  localparam int ROUND_T = 2 * SCAN_T + GAP_T;
  localparam int TW      = $clog2(ROUND_T);
  localparam int SW      = $clog2(N_DRV);

  ks_state_e        state;
  logic [TW-1:0]    tcnt;
  logic [TW-1:0]    pos;
  logic [SW-1:0]    slot;
  logic             tick, in_scan, slot_end, smp, pass_sel;
  logic             req_q, slp_cap, scan_on;
  logic [N_SNS-1:0] sense_s;
  logic [N_DRV-1:0] line_en, sleep_en, act, oh;
  logic [NK-1:0]    pass_a, pass_b;

  kscan_sync #(.W(N_SNS)) u_sync (.clk(clk), .rst_n(rst_n), .d(key_in), .q(sense_s));
  kscan_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  // Line ownership and rest pattern
  always_comb begin
    line_en = '1;
    if (line_mode[1])      line_en[1:0] = 2'b00;
    else if (line_mode[0]) line_en[0]   = 1'b0;
  end

  always_comb begin
    int hi;
    case (sleep_sel)
      2'd1:    hi = 1;
      2'd2:    hi = 2;
      2'd3:    hi = N_DRV - 1;
      default: hi = N_DRV;
    endcase
    for (int k = 0; k < N_DRV; k++) sleep_en[k] = (k >= N_DRV - hi);
  end

  assign act = line_en & sleep_en;

  // Position inside the round
  assign scan_on  = (state == KS_SCAN);
  assign in_scan  = scan_on && (tcnt < TW'(2 * SCAN_T));
  assign pass_sel = (tcnt >= TW'(SCAN_T));
  assign pos      = pass_sel ? (tcnt - TW'(SCAN_T)) : tcnt;
  assign slot     = SW'(pos / TW'(SLOT_T));
  assign slot_end = ((pos % TW'(SLOT_T)) == TW'(SLOT_T - 1));
  assign smp      = tick && in_scan && slot_end;

  always_comb begin
    for (int k = 0; k < N_DRV; k++) oh[k] = (slot == SW'(k));
    if (scan_on) drive_out = in_scan ? (oh & act) : '0;
    else         drive_out = act;
  end

  kscan_capture #(.N_DRV(N_DRV), .N_SNS(N_SNS)) u_cap (
    .clk(clk), .rst_n(rst_n), .smp(smp), .pass_sel(pass_sel), .slot(slot),
    .sense(sense_s), .act(act), .pass_a(pass_a), .pass_b(pass_b)
  );

  // Round sequencing and request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= KS_IDLE;
      tcnt      <= '0;
      key_bits  <= '0;
      req_q     <= 1'b0;
      sleep_ack <= 1'b0;
      slp_cap   <= 1'b0;
    end else begin
      case (state)
        KS_IDLE: begin
          if (|sense_s) begin
            state   <= KS_SCAN;
            tcnt    <= '0;
            slp_cap <= |sleep_sel;
          end
        end
        KS_SCAN: begin
          if (tick) begin
            if (tcnt == TW'(ROUND_T - 1)) begin
              tcnt <= '0;
              if (pass_a == pass_b) begin
                if (|pass_a) begin
                  key_bits  <= pass_a;
                  sleep_ack <= slp_cap;
                  req_q     <= 1'b1;
                  state     <= KS_WAIT;
                end else begin
                  state <= KS_IDLE;
                end
              end else begin
                slp_cap <= |sleep_sel;
              end
            end else begin
              tcnt <= tcnt + TW'(1);
            end
          end
        end
        KS_WAIT: begin
          if (rd_done) begin
            req_q   <= 1'b0;
            state   <= KS_SCAN;
            tcnt    <= '0;
            slp_cap <= |sleep_sel;
          end
        end
        default: state <= KS_IDLE;
      endcase
    end
  end

  assign req_n = ~(req_q & ~cs_busy);
endmodule

// File: rtl/kscan_chk.sv
`timescale 1ns/1ps
module kscan_chk #(
  parameter int N_DRV = 6,
  parameter int NK    = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_busy,
  input logic             rd_done,
  input logic [1:0]       line_mode,
  input logic [N_DRV-1:0] drive_out,
  input logic [NK-1:0]    key_bits,
  input logic             req_n,
  input logic             req_q,
  input logic             scan_on
);
  p_cs_masks_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_busy |-> req_n);

  p_line0_freed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_mode != 2'b00) |-> !drive_out[0]);

  p_line1_freed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_mode[1] |-> !drive_out[1]);

  p_one_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
    scan_on |-> $onehot0(drive_out));

  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !rd_done) |=> req_q);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && rd_done) |=> !req_q);

  p_keys_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !rd_done) |=> $stable(key_bits));
endmodule

bind kscan_top kscan_chk #(.N_DRV(N_DRV), .NK(NK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_busy(cs_busy), .rd_done(rd_done),
  .line_mode(line_mode), .drive_out(drive_out), .key_bits(key_bits),
  .req_n(req_n), .req_q(req_q), .scan_on(scan_on)
);

// File: tb/sim_kscan_top.sv
`timescale 1ns/1ps
module sim_kscan_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  key_in;
  logic [1:0]  sleep_sel = 2'b00;
  logic [1:0]  line_mode = 2'b00;
  logic        cs_busy = 1'b0;
  logic        rd_done = 1'b0;
  logic [5:0]  drive_out;
  logic [29:0] key_bits;
  logic        sleep_ack;
  logic        req_n;
  logic [29:0] press = '0;

  always #2.5 clk = ~clk;

  kscan_top u0 (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .sleep_sel(sleep_sel),
    .line_mode(line_mode), .cs_busy(cs_busy), .rd_done(rd_done),
    .drive_out(drive_out), .key_bits(key_bits), .sleep_ack(sleep_ack),
    .req_n(req_n)
  );

  // Matrix model: key (line k, input j) joins drive k to sense j.
  always_comb begin
    key_in = '0;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 5; j++)
        if (drive_out[k] && press[k*5+j]) key_in[j] = 1'b1;
  end

  int cycle_cnt = 0;
  always @(posedge clk) cycle_cnt <= cycle_cnt + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [29:0] keys;
    logic        sa;
    int          t0;
    int          lo;
    int          hi;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_req(input logic [29:0] k, input logic sa,
                            input int lo, input int hi, input string tag);
    exp_t e;
    e.keys = k; e.sa = sa; e.t0 = cycle_cnt; e.lo = lo; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_drained(input int lim, input string tag);
    for (int i = 0; i < lim && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, tag, "request never came", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic ack_release();
    @(negedge clk);
    rd_done = 1'b1;
    press   = '0;
    @(negedge clk);
    rd_done = 1'b0;
    repeat (1000) @(negedge clk);
  endtask

  task automatic do_press(input logic [29:0] p, input logic [29:0] ek,
                          input logic esa, input string tag);
    expect_req(ek, esa, 800, 808, tag);
    press = p;
    wait_drained(2000, tag);
    ack_release();
  endtask

  task automatic idle_is(input logic [5:0] exp, input string tag);
    @(negedge clk);
    #1;
    chk(drive_out == exp, tag, "rest pattern", drive_out, exp);
  endtask

  // Monitor: scoreboard pop on each unmasked falling edge of req_n.
  initial begin
    logic pr;
    logic pc;
    exp_t e;
    int   lat;
    pr = 1'b1;
    pc = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && pr && !req_n && !cs_busy && !pc) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected request, keys", key_bits, 0);
        end else begin
          e   = exp_q.pop_front();
          lat = cycle_cnt - e.t0;
          chk(key_bits == e.keys, e.tag, "key word", key_bits, e.keys);
          chk(sleep_ack == e.sa, e.tag, "sleep ack", sleep_ack, e.sa);
          chk(lat >= e.lo && lat <= e.hi, e.tag, "latency", lat, e.lo);
        end
      end
      pr = req_n;
      pc = cs_busy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung at cycle %0d", cycle_cnt);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(key_bits == '0, "R11", "keys in reset", key_bits, 0);
    chk(req_n == 1'b1, "R11", "req_n in reset", req_n, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(sleep_ack == 1'b0, "R11", "sleep ack after reset", sleep_ack, 0);
    chk(drive_out == 6'h3F, "R2", "rest pattern normal", drive_out, 6'h3F);
    repeat (20) @(negedge clk);

    // R1/R3: single key at line 3, input 2 -> bit 17
    do_press(30'd1 << 17, 30'd1 << 17, 1'b0, "R1");

    // R12: line 2 driven in ticks 128..191 of the first pass
    expect_req(30'd1 << 14, 1'b0, 800, 808, "R12");
    press = 30'd1 << 14;
    repeat (141) @(negedge clk);
    #1;
    chk(drive_out == 6'b000100, "R12", "drive in slot 2", drive_out, 6'b000100);
    wait_drained(2000, "R12");
    ack_release();

    // R5: two keys at once
    do_press((30'd1 << 0) | (30'd1 << 29), (30'd1 << 0) | (30'd1 << 29), 1'b0, "R5");

    // R4: key changes during the second pass -> 1600T
    expect_req(30'd1 << 1, 1'b0, 1600, 1608, "R4");
    press = 30'd1 << 25;
    repeat (500) @(negedge clk);
    press = 30'd1 << 1;
    wait_drained(2500, "R4");
    ack_release();

    // R4: short press never reported
    press = 30'd1 << 12;
    repeat (300) @(negedge clk);
    press = '0;
    repeat (2500) @(negedge clk);
    #1;
    chk(req_n == 1'b1, "R4", "short press req_n", req_n, 1);
    chk(drive_out == 6'h3F, "R5", "back to rest after release", drive_out, 6'h3F);

    // R6/R7: held key, ack, repeat request, chip-select masking
    expect_req(30'd1 << 7, 1'b0, 800, 808, "R6");
    press = 30'd1 << 7;
    wait_drained(2000, "R6");
    @(negedge clk);
    rd_done = 1'b1;
    expect_req(30'd1 << 7, 1'b0, 799, 808, "R6");
    @(negedge clk);
    rd_done = 1'b0;
    #1;
    chk(req_n == 1'b1, "R6", "req_n after read-done", req_n, 1);
    wait_drained(2000, "R6");
    @(negedge clk);
    cs_busy = 1'b1;
    #1;
    chk(req_n == 1'b1, "R7", "req_n with cs busy", req_n, 1);
    @(negedge clk);
    cs_busy = 1'b0;
    #1;
    chk(req_n == 1'b0, "R7", "req_n after cs idle", req_n, 0);
    ack_release();

    // R8: released drive lines
    line_mode = 2'b01;
    idle_is(6'h3E, "R8");
    do_press((30'd1 << 0) | (30'd1 << 12), 30'd1 << 12, 1'b0, "R8");
    line_mode = 2'b10;
    idle_is(6'h3C, "R8");
    do_press((30'd1 << 6) | (30'd1 << 29), 30'd1 << 29, 1'b0, "R8");
    line_mode = 2'b00;

    // R9/R10: sleep rest patterns and wake
    sleep_sel = 2'b01;
    idle_is(6'h20, "R9");
    press = 30'd1 << 0;
    repeat (2000) @(negedge clk);
    #1;
    chk(req_n == 1'b1, "R9", "no wake from low line", req_n, 1);
    press = '0;
    sleep_sel = 2'b10;
    idle_is(6'h30, "R9");
    sleep_sel = 2'b11;
    idle_is(6'h3E, "R9");
    do_press((30'd1 << 3) | (30'd1 << 5) | (30'd1 << 25),
             (30'd1 << 5) | (30'd1 << 25), 1'b1, "R10");
    sleep_sel = 2'b00;

    // R11: reset while a request is pending
    expect_req(30'd1 << 9, 1'b0, 800, 808, "R11");
    press = 30'd1 << 9;
    wait_drained(2000, "R11");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(key_bits == '0, "R11", "keys cleared", key_bits, 0);
    chk(req_n == 1'b1, "R11", "req_n released", req_n, 1);
    press = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    chk(exp_q.size() == 0, "R3", "leftover expectations", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule